// File: doc/BRIEF.md
# In-Order Completion Window Checker

This block is a synthesizable monitor for a simple request/completion handshake made of two single-bit strobes. Each request is held as its own pending entry, so several requests may be waiting at the same time. Each completion strobe is given to the oldest pending entry and to no other entry. A completion counts only when it falls inside a bounded window of cycles after its request. The block reports every retired entry, every expired entry, every completion that has no valid partner, and every request that finds no free storage.

Each pending entry carries its own age counter. The window bounds and the number of entries are parameters. Every verdict is a registered one-cycle pulse that appears in the cycle after the cycle that caused it. The pending count is also registered, and is brought out so that the surrounding logic or a bench can see how much is outstanding.

Top module: `ioc_checker`

## Requirements
- R1: A completion sampled k cycles after the head entry's request, with WIN_MIN <= k <= WIN_MAX (k = WIN_MAX included), retires that entry and drives pass_o high for exactly the next cycle.
- R2: A completion sampled in the same cycle as a request never matches that request. If nothing else is pending, it is reported as spurious, and the request itself is still enqueued.
- R3: One completion strobe retires at most one entry, even when several entries are pending and all of them lie inside their windows.
- R4: Entries retire strictly in the order their requests arrived. The oldest pending entry takes the next completion.
- R5: If the head entry reaches age WIN_MAX with no completion in that cycle, timeout_o pulses in the next cycle and the entry is dropped. Younger entries stay pending and are still checked.
- R6: A completion sampled while no entry is pending drives spurious_o high in the next cycle.
- R7: A completion sampled while the head entry's age is below WIN_MIN drives spurious_o high in the next cycle. The head entry stays pending.
- R8: A request sampled while DEPTH entries were pending at the start of the cycle drives overflow_o high in the next cycle and is not enqueued. This holds even if the head retires in the same cycle.
- R9: outstanding_o equals the number of pending entries after each clock edge.
- R10: While rst is high at a clock edge, all entries are cleared, outstanding_o becomes 0 and every pulse output becomes 0.
- R11: In any cycle, at most one of pass_o, timeout_o and spurious_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request strobe, sampled every cycle |
| done_i | input | 1 | Completion strobe, sampled every cycle |
| pass_o | output | 1 | Head entry retired by an in-window completion |
| timeout_o | output | 1 | Head entry expired at the window limit |
| spurious_o | output | 1 | Completion with no pending entry, or an early completion |
| overflow_o | output | 1 | Request refused because storage was full |
| outstanding_o | output | $clog2(DEPTH+1) | Number of pending entries |

## Verification
The bench builds the checker with WIN_MIN=2, WIN_MAX=6 and DEPTH=3. The short upper bound makes expiry happen within a handful of cycles. A lower bound of 2 makes the early-completion case reachable, which a lower bound of 1 hides, because at age 1 every completion already matches. A depth of 3 lets the queue fill with only a few back-to-back requests, so a full queue meeting a same-cycle retire can be driven directly. The scoreboard holds its own list of pending request times and derives every expected pulse and count from that list.

// File: rtl/ioc_pkg.sv
package ioc_pkg;
  // One cycle's worth of verdict pulses, registered at the top.
  typedef struct packed {
    logic pass;
    logic timeout;
    logic spurious;
    logic overflow;
  } ioc_flags_t;
endpackage

// File: rtl/ioc_age_slot.sv
module ioc_age_slot #(
  parameter int AGE_W   = 4,
  parameter int AGE_CAP = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             clear,
  output logic             valid_o,
  output logic [AGE_W-1:0] age_o
);
  localparam logic [AGE_W-1:0] CAP = AGE_W'(AGE_CAP);

  // A newly loaded entry reads age 1 in the cycle after its request.
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      age_o   <= '0;
    end else if (load) begin
      valid_o <= 1'b1;
      age_o   <= AGE_W'(1);
    end else if (clear) begin
      valid_o <= 1'b0;
      age_o   <= '0;
    end else if (valid_o && age_o != CAP) begin
      age_o   <= age_o + 1'b1;
    end
  end

  AST_LOAD_FREE_SLOT: assert property (@(posedge clk) disable iff (rst)
    load |-> !valid_o); // R8
endmodule

// File: rtl/ioc_head_judge.sv
module ioc_head_judge #(
  parameter int AGE_W   = 4,
  parameter int WIN_MIN = 1,
  parameter int WIN_MAX = 10
) (
  input  logic             head_valid,
  input  logic [AGE_W-1:0] head_age,
  input  logic             done,
  output logic             match,
  output logic             expire,
  output logic             spurious
);
  localparam logic [AGE_W-1:0] LO = AGE_W'(WIN_MIN);
  localparam logic [AGE_W-1:0] HI = AGE_W'(WIN_MAX);

  always_comb begin
    match    = done && head_valid && (head_age >= LO);
    expire   = !done && head_valid && (head_age >= HI);
    spurious = done && !match;
  end
endmodule

// File: rtl/ioc_queue_ctrl.sv
module ioc_queue_ctrl #(
  parameter int DEPTH = 4,
  parameter int PTR_W = 2,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_req,
  input  logic             pop,
  output logic             push,
  output logic             full,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [CNT_W-1:0] count
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CAP  = CNT_W'(DEPTH);

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  // Fullness is judged on the count at the start of the cycle.
  assign full = (count == CAP);
  assign push = push_req && !full;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    pop |-> count != '0); // R5
  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    count <= CAP); // R8
endmodule

// File: rtl/ioc_checker.sv
module ioc_checker #(
  parameter int WIN_MIN = 1,
  parameter int WIN_MAX = 10,
  parameter int DEPTH   = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_i,
  input  logic                       done_i,
  output logic                       pass_o,
  output logic                       timeout_o,
  output logic                       spurious_o,
  output logic                       overflow_o,
  output logic [$clog2(DEPTH+1)-1:0] outstanding_o
);
  import ioc_pkg::*;

  localparam int AGE_W = $clog2(WIN_MAX + 1);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] slot_valid;
  logic [DEPTH-1:0] slot_load;
  logic [DEPTH-1:0] slot_clear;
  logic [AGE_W-1:0] slot_age [DEPTH];

  logic             push, full, retire;
  logic             hit, expire, stray;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             head_valid;
  logic [AGE_W-1:0] head_age;
  ioc_flags_t       flags_d, flags_q;

  assign retire = hit || expire;

  ioc_queue_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_queue (
    .clk      (clk),
    .rst      (rst),
    .push_req (req_i),
    .pop      (retire),
    .push     (push),
    .full     (full),
    .wr_ptr   (wr_ptr),
    .rd_ptr   (rd_ptr),
    .count    (count)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    assign slot_load[i]  = push && (wr_ptr == PTR_W'(i));
    assign slot_clear[i] = retire && (rd_ptr == PTR_W'(i));
    ioc_age_slot #(.AGE_W(AGE_W), .AGE_CAP(WIN_MAX)) u_slot (
      .clk     (clk),
      .rst     (rst),
      .load    (slot_load[i]),
      .clear   (slot_clear[i]),
      .valid_o (slot_valid[i]),
      .age_o   (slot_age[i])
    );
  end

  assign head_valid = slot_valid[rd_ptr];
  assign head_age   = slot_age[rd_ptr];

  ioc_head_judge #(.AGE_W(AGE_W), .WIN_MIN(WIN_MIN), .WIN_MAX(WIN_MAX)) u_judge (
    .head_valid (head_valid),
    .head_age   (head_age),
    .done       (done_i),
    .match      (hit),
    .expire     (expire),
    .spurious   (stray)
  );

  always_comb begin
    flags_d.pass     = hit;
    flags_d.timeout  = expire;
    flags_d.spurious = stray;
    flags_d.overflow = req_i && full;
  end

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= flags_d;
  end

  assign pass_o        = flags_q.pass;
  assign timeout_o     = flags_q.timeout;
  assign spurious_o    = flags_q.spurious;
  assign overflow_o    = flags_q.overflow;
  assign outstanding_o = count;

  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pass_o, timeout_o, spurious_o})); // R11
  AST_OVERFLOW_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
    overflow_o |-> $past(outstanding_o) == CNT_W'(DEPTH)); // R8
  AST_PASS_RETIRES_ONE: assert property (@(posedge clk) disable iff (rst)
    (pass_o && !$past(req_i)) |-> outstanding_o == CNT_W'($past(outstanding_o) - 1'b1)); // R3
  AST_TIMEOUT_HAD_ENTRY: assert property (@(posedge clk) disable iff (rst)
    timeout_o |-> $past(outstanding_o) != '0); // R5
endmodule

// File: tb/sim_ioc_checker.sv
module sim_ioc_checker;
  localparam int WMIN  = 2;
  localparam int WMAX  = 6;
  localparam int DEPTH = 3;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0;
  logic done = 1'b0;
  logic pass_o, timeout_o, spurious_o, overflow_o;
  logic [CW-1:0] outstanding_o;

  always #2 clk = ~clk;

  ioc_checker #(.WIN_MIN(WMIN), .WIN_MAX(WMAX), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .req_i(req), .done_i(done),
    .pass_o(pass_o), .timeout_o(timeout_o), .spurious_o(spurious_o),
    .overflow_o(overflow_o), .outstanding_o(outstanding_o)
  );

  typedef struct {
    logic  p, t, s, o;
    int    cnt;
    string tag;
  } exp_t;

  exp_t  expq[$];
  int    pend[$];
  int    tnow   = 0;
  int    checks = 0;
  int    errors = 0;
  bit    over   = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and predicts its outcome.
  task automatic step(input logic r, input logic d, input string tag);
    exp_t e;
    bit   was_full;
    int   age;
    @(negedge clk);
    req = r; done = d;
    e.p = 0; e.t = 0; e.s = 0; e.o = 0; e.tag = tag;
    was_full = (pend.size() == DEPTH);
    age = (pend.size() > 0) ? tnow - pend[0] : 0;
    if (d) begin
      if (pend.size() > 0 && age >= WMIN) begin e.p = 1; void'(pend.pop_front()); end
      else e.s = 1;
    end else if (pend.size() > 0 && age >= WMAX) begin
      e.t = 1; void'(pend.pop_front());
    end
    if (r) begin
      if (was_full) e.o = 1;
      else pend.push_back(tnow);
    end
    e.cnt = pend.size();
    expq.push_back(e);
    tnow++;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, tag);
  endtask

  // Monitor: compares outputs after each edge against the predictions.
  always @(posedge clk) begin
    #1;
    if (!rst) chk("R11", "verdict_onehot", int'($onehot0({pass_o, timeout_o, spurious_o})), 1);
    if (expq.size() > 0) begin
      exp_t e;
      e = expq.pop_front();
      chk(e.tag, "pass_o", int'(pass_o), int'(e.p));
      chk(e.tag, "timeout_o", int'(timeout_o), int'(e.t));
      chk(e.tag, "spurious_o", int'(spurious_o), int'(e.s));
      chk(e.tag, "overflow_o", int'(overflow_o), int'(e.o));
      chk({e.tag, "/R9"}, "outstanding_o", int'(outstanding_o), e.cnt);
    end
  end

  task automatic check_reset_state();
    chk("R10", "pass_o", int'(pass_o), 0);
    chk("R10", "timeout_o", int'(timeout_o), 0);
    chk("R10", "spurious_o", int'(spurious_o), 0);
    chk("R10", "overflow_o", int'(overflow_o), 0);
    chk("R10", "outstanding_o", int'(outstanding_o), 0);
  endtask

  task automatic finish_run();
    if (!over) begin
      over = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [15:0] lf;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_reset_state();
    rst = 0;
    idle(2, "R9");

    // Overlapping requests, two completions, oldest first
    step(1, 0, "R4"); step(0, 0, "R4"); step(1, 0, "R4");
    step(0, 1, "R4"); step(0, 1, "R3");
    idle(2, "R9");

    // Same two requests, single completion: second must expire
    step(1, 0, "R5"); step(0, 0, "R5"); step(1, 0, "R5");
    step(0, 1, "R3");
    idle(8, "R5");

    // Completion with nothing pending
    step(0, 1, "R6"); idle(1, "R6");
    // Request and completion in the same cycle
    step(1, 1, "R2"); step(0, 0, "R2"); step(0, 1, "R1");
    idle(1, "R9");

    // Early completion keeps the head pending
    step(1, 0, "R7"); step(0, 1, "R7"); step(0, 1, "R7");
    idle(1, "R9");

    // Completion exactly at the upper bound
    step(1, 0, "R1"); idle(5, "R1"); step(0, 1, "R1");
    // Expiry then late completion
    step(1, 0, "R5"); idle(6, "R5"); step(0, 1, "R6");
    idle(1, "R9");

    // Full queue: refused request even with a same-cycle retire
    step(1, 0, "R8"); step(1, 0, "R8"); step(1, 0, "R8");
    step(1, 1, "R8"); step(1, 0, "R8");
    step(0, 1, "R8"); step(0, 1, "R8"); step(0, 1, "R8");
    idle(8, "R5");

    // Reset with entries pending
    step(1, 0, "R10"); step(1, 0, "R10");
    @(negedge clk);
    rst = 1; req = 0; done = 0;
    pend.delete();
    @(posedge clk); #1;
    check_reset_state();
    @(negedge clk);
    rst = 0;
    idle(2, "R10");

    // Pseudo-random traffic
    lf = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[0] & lf[2], lf[4] & lf[7], "R4");
    end
    idle(10, "R5");
    @(negedge clk); req = 0; done = 0;
    repeat (2) @(posedge clk);
    #2;
    finish_run();
  end
endmodule